// File: doc/BRIEF.md
# Delayed Branch Decode and Annul

This block sits at the decode stage of a 32-bit RISC pipeline and handles control-transfer words. It recognises three kinds: an absolute call, a conditional PC-relative branch and a return through a register. For each transfer it decides whether the jump is taken and forms the target address. It then raises a redirect request toward fetch.

Every transfer is followed by one delay-slot instruction. That instruction normally executes. A conditional branch can carry an annul bit. When that bit is set and the branch is not taken, the block squashes the next valid instruction that reaches decode, and that instruction is the delay slot. Calls and returns always let their delay slot run.

A conditional branch whose condition depends on the ALU flags cannot resolve until the flags are valid. It stalls decode while it waits. The return target is read from the register file outside this block and arrives as an input value.

Top module: `dbr_decode`

## Requirements
- R1: A word with bits [31:30] = 2'b01 is a call. When valid and not squashed, it raises `redirect_o` with `target_o` = {instr_i[29:0], 2'b00}.
- R2: A conditional branch has opcode 8'h02 in [31:24], the annul bit in [23], the condition in [22:19] and a signed offset in [18:0]. When taken, `target_o` = pc_i + (sign-extended offset shifted left by two).
- R3: Conditions use flags_i = {N,Z,C,V}. The codes are:
  - 0 always, 1 never
  - 2 Z, 3 !Z
  - 4 C, 5 !C
  - 6 N, 7 !N
  - 8 V, 9 !V
  - 10 C&!Z, 11 !C|Z
  - 12 N==V, 13 N!=V
  - 14 !Z&(N==V), 15 Z|(N!=V)

  `redirect_o` is high exactly when the condition holds.
- R4: Codes 0 and 1 resolve without flags. Any other code with `flags_valid_i` low raises `stall_o` and keeps `redirect_o` low. It resolves in the first cycle in which the flags are valid.
- R5: A return has opcode 8'h81 in [31:24]. It always redirects, with `target_o` = `ret_target_i`.
- R6: A resolved branch with the annul bit set and a false condition squashes the next valid instruction. That instruction shows `squash_o` high and produces no redirect and no stall, whatever it encodes.
- R7: A taken annulled branch, any branch with the annul bit clear, a call and a return never cause a squash.
- R8: Any other word, and any cycle without a redirect, gives `redirect_o` low and `target_o` = 0. Non-transfer words never stall.
- R9: After reset no squash is pending.
- R10: With `instr_valid_i` low, `redirect_o`, `stall_o` and `squash_o` are low. A pending squash survives such cycles and applies to the next valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Decode slot holds an instruction |
| instr_i | input | 32 | Instruction word in decode |
| pc_i | input | 32 | Byte address of instr_i |
| flags_i | input | 4 | ALU flags {N,Z,C,V} |
| flags_valid_i | input | 1 | flags_i reflect all older instructions |
| ret_target_i | input | 32 | Return address read from the register file |
| redirect_o | output | 1 | Transfer taken, fetch from target_o |
| target_o | output | 32 | Target byte address, zero without redirect |
| stall_o | output | 1 | Branch waits for valid flags |
| squash_o | output | 1 | Current instruction is an annulled delay slot |

## Verification
The bench targets the annul corner cases. These include an annulled not-taken branch whose delay slot is itself a call, which a faulty design would let redirect. They also include idle cycles between a branch and its slot, which a design that clears the pending squash too early would let through. It sweeps all sixteen condition codes with random flags, so an inverted or swapped pair shows up as a wrong redirect. It also exercises negative offsets, which reveal a missing sign extension. Stalls with invalid flags are checked against codes 0 and 1, since a design that waits on those would hang branch-always loops.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_CALL = 2'd1,
    XFER_BCC  = 2'd2,
    XFER_RET  = 2'd3
  } xfer_e;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned OFF_W    = 19;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned ANNUL_B  = 23;
  localparam int unsigned COND_LSB = 19;
endpackage

// File: rtl/dbr_cond_eval.sv
module dbr_cond_eval
  import dbr_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [3:0]        flags_i,   // {N,Z,C,V}
  output logic              take_o,
  output logic              needs_flags_o
);
  logic n, z, c, v, base;
  assign {n, z, c, v} = flags_i;

  // even code = base condition, odd code = its inverse
  always_comb begin
    unique case (cond_i[3:1])
      3'd0:    base = 1'b1;
      3'd1:    base = z;
      3'd2:    base = c;
      3'd3:    base = n;
      3'd4:    base = v;
      3'd5:    base = c & ~z;
      3'd6:    base = (n == v);
      default: base = ~z & (n == v);
    endcase
  end

  assign take_o        = base ^ cond_i[0];
  assign needs_flags_o = (cond_i[3:1] != 3'd0);
endmodule

// File: rtl/dbr_target_gen.sv
module dbr_target_gen
  import dbr_pkg::*;
(
  input  xfer_e           kind_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] ret_target_i,
  output logic [XLEN-1:0] target_o
);
  localparam int unsigned SEXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] rel_off;
  assign rel_off = {{SEXT_W{instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0], 2'b00};

  always_comb begin
    unique case (kind_i)
      XFER_CALL: target_o = {instr_i[XLEN-3:0], 2'b00};
      XFER_BCC:  target_o = pc_i + rel_off;
      XFER_RET:  target_o = ret_target_i;
      default:   target_o = '0;
    endcase
  end
endmodule

// File: rtl/dbr_slot_ctrl.sv
module dbr_slot_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic consume_i,
  input  logic arm_i,
  output logic pending_o
);
  // consuming any instruction clears the mark unless it arms a new one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pending_o <= 1'b0;
    else if (consume_i) pending_o <= arm_i;
  end
endmodule

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter logic [1:0] OPC_CALL = 2'b01,
  parameter logic [7:0] OPC_BCC  = 8'h02,
  parameter logic [7:0] OPC_RET  = 8'h81
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [3:0]      flags_i,
  input  logic            flags_valid_i,
  input  logic [XLEN-1:0] ret_target_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            stall_o,
  output logic            squash_o
);
  xfer_e           kind;
  logic            cond_take, needs_flags, pending;
  logic            live, wait_flags, taken, consume, arm;
  logic [XLEN-1:0] tgt;

  always_comb begin
    if (instr_i[XLEN-1 -: 2] == OPC_CALL)     kind = XFER_CALL;
    else if (instr_i[XLEN-1 -: 8] == OPC_BCC) kind = XFER_BCC;
    else if (instr_i[XLEN-1 -: 8] == OPC_RET) kind = XFER_RET;
    else                                      kind = XFER_NONE;
  end

  dbr_cond_eval u_cond (
    .cond_i        (instr_i[COND_LSB +: COND_W]),
    .flags_i       (flags_i),
    .take_o        (cond_take),
    .needs_flags_o (needs_flags)
  );

  dbr_target_gen u_tgt (
    .kind_i       (kind),
    .instr_i      (instr_i),
    .pc_i         (pc_i),
    .ret_target_i (ret_target_i),
    .target_o     (tgt)
  );

  assign live       = instr_valid_i & ~pending;
  assign wait_flags = live & (kind == XFER_BCC) & needs_flags & ~flags_valid_i;
  assign taken      = live & ~wait_flags &
                      ((kind == XFER_CALL) | (kind == XFER_RET) |
                       ((kind == XFER_BCC) & cond_take));
  assign arm        = live & ~wait_flags & (kind == XFER_BCC) &
                      instr_i[ANNUL_B] & ~cond_take;
  assign consume    = instr_valid_i & ~wait_flags;

  dbr_slot_ctrl u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .consume_i (consume),
    .arm_i     (arm),
    .pending_o (pending)
  );

  assign redirect_o = taken;
  assign target_o   = taken ? tgt : '0;
  assign stall_o    = wait_flags;
  assign squash_o   = instr_valid_i & pending;

  // R4
  stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !redirect_o);

  // R6
  squash_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (!redirect_o && !stall_o));

  // R6
  squash_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !squash_o);

  // R1
  tgt_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && kind != XFER_RET) |-> (target_o[1:0] == 2'b00));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> (!redirect_o && !stall_o && !squash_o));

  // R8
  no_redirect_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> (target_o == '0));
endmodule

// File: tb/dbr_decode_bench.sv
module dbr_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [3:0]  flags = '0;
  logic        fv = 1'b0;
  logic [31:0] rt = '0;
  logic        redirect, stall, squash;
  logic [31:0] target;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit m_pend = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbr_decode u_dbr_decode (
    .clk_i (clk), .rst_ni (rst_n), .instr_valid_i (valid), .instr_i (instr),
    .pc_i (pc), .flags_i (flags), .flags_valid_i (fv), .ret_target_i (rt),
    .redirect_o (redirect), .target_o (target), .stall_o (stall), .squash_o (squash)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit cond_ok(logic [3:0] c, logic [3:0] f);
    bit n, z, cf, v;
    {n, z, cf, v} = f;
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return cf;
      4'd5:  return !cf;
      4'd6:  return n;
      4'd7:  return !n;
      4'd8:  return v;
      4'd9:  return !v;
      4'd10: return cf && !z;
      4'd11: return !cf || z;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] w, logic [31:0] p, logic [3:0] f,
                      bit fvl, logic [31:0] r);
    bit sq, live, iscall, isb, isr, needf, st, ok, tk, arm;
    logic [31:0] tg;
    string rtag, ttag;
    @(negedge clk);
    valid = v; instr = w; pc = p; flags = f; fv = fvl; rt = r;
    #1;
    sq     = v && m_pend;
    live   = v && !m_pend;
    iscall = (w[31:30] == 2'b01);
    isb    = !iscall && (w[31:24] == 8'h02);
    isr    = !iscall && (w[31:24] == 8'h81);
    needf  = (w[22:19] > 4'd1);
    ok     = cond_ok(w[22:19], f);
    st     = live && isb && needf && !fvl;
    tk     = live && !st && (iscall || isr || (isb && ok));
    arm    = live && isb && !st && w[23] && !ok;
    if (!tk)         tg = 32'd0;
    else if (iscall) tg = {w[29:0], 2'b00};
    else if (isb)    tg = p + {{11{w[18]}}, w[18:0], 2'b00};
    else             tg = r;
    rtag = !v ? "R10" : sq ? "R6" : iscall ? "R1" : isb ? "R3" : isr ? "R5" : "R8";
    ttag = !v ? "R10" : sq ? "R6" : iscall ? "R1" : isb ? "R2" : isr ? "R5" : "R8";
    chk(rtag, "redirect", {31'd0, redirect}, {31'd0, tk});
    chk(ttag, "target", target, tg);
    chk(st ? "R4" : "R8", "stall", {31'd0, stall}, {31'd0, st});
    chk(m_pend ? "R6" : "R7", "squash", {31'd0, squash}, {31'd0, sq});
    if (v && !st) m_pend = arm;
  endtask

  function automatic logic [31:0] bcc(bit an, logic [3:0] c, logic [18:0] off);
    return {8'h02, an, c, off};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: no squash pending after reset
    valid = 1'b1; instr = 32'hC000_0000; #1;
    chk("R9", "squash in reset", {31'd0, squash}, 32'd0);
    rst_n = 1'b1;
    step(1, 32'hC000_0000, 32'h100, 4'h0, 1, 0);
    chk("R9", "squash after reset", {31'd0, squash}, 32'd0);

    // R6: annulled not-taken (EQ, Z=0); slot is a call, must be squashed
    step(1, bcc(1, 4'd2, 19'h00010), 32'h200, 4'b0000, 1, 0);
    step(1, {2'b01, 30'h123}, 32'h204, 4'h0, 1, 0);
    chk("R6", "squashed call", {31'd0, squash}, 32'd1);
    // R6: annulled taken (EQ, Z=1) keeps slot
    step(1, bcc(1, 4'd2, 19'h7FFF0), 32'h300, 4'b0100, 1, 0);
    step(1, 32'hC000_0000, 32'h304, 4'h0, 1, 0);
    chk("R6", "taken annul slot kept", {31'd0, squash}, 32'd0);
    // R7: annul clear, not taken -> no squash
    step(1, bcc(0, 4'd2, 19'h4), 32'h400, 4'b0000, 1, 0);
    step(1, {8'h81, 24'h0}, 32'h404, 4'h0, 1, 32'hDEAD_BEE0);
    chk("R7", "no annul slot kept", {31'd0, redirect}, 32'd1);
    // R10: idle cycles between annulled branch and its slot
    step(1, bcc(1, 4'd1, 19'h4), 32'h500, 4'h0, 0, 0);
    step(0, 32'h0, 32'h0, 4'h0, 0, 0);
    step(0, 32'h0, 32'h0, 4'h0, 0, 0);
    step(1, {2'b01, 30'h5}, 32'h504, 4'h0, 1, 0);
    chk("R10", "squash survives idle", {31'd0, squash}, 32'd1);
    // R4: wait on flags, then resolve; always needs no flags
    step(1, bcc(0, 4'd3, 19'h8), 32'h600, 4'b0000, 0, 0);
    chk("R4", "stall while flags invalid", {31'd0, stall}, 32'd1);
    step(1, bcc(0, 4'd3, 19'h8), 32'h600, 4'b0000, 1, 0);
    chk("R4", "resolved target", target, 32'h620);
    step(1, bcc(0, 4'd0, 19'h7FFFF), 32'h700, 4'h0, 0, 0);
    chk("R4", "always ignores flag wait", target, 32'h6FC);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      int k;
      k = int'($urandom % 6);
      case (k)
        0:       w = {2'b01, 30'($urandom)};
        1, 2:    w = bcc(1'($urandom), 4'($urandom), 19'($urandom));
        3:       w = {8'h81, 24'($urandom)};
        default: w = {2'b11, 30'($urandom)};
      endcase
      step(($urandom % 8) != 0, w, {30'($urandom), 2'b00}, 4'($urandom),
           ($urandom % 4) != 0, $urandom);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule